// File: doc/BRIEF.md
# Phase-Aligned Multi-Channel Quadrature NCO

This block is the local-oscillator bank of a multi-channel digital down-converter. It produces sine and cosine samples for several receive channels in parallel. Every channel runs its own phase accumulator, and all accumulators are clocked by the ADC sample clock (nominally 24 MHz). Each channel produces a new signed I/Q pair on every clock. Each accumulator adds its channel's tuning word once per enabled clock. The output frequency is tuning_word × fs / 2^32, which gives a resolution of about 5.6 mHz at 24 MHz.

Channels are meant to be used in pairs. The two words of a pair differ by a small fixed step, for example 5, 6, 7 and 8 MHz, each paired with a partner about 3749.941 Hz higher. The phase difference within a pair is only meaningful if every channel starts from the same phase. For that reason, tuning words are written into a pending register and become active only at a shared start strobe. The same strobe also zeroes every accumulator on the same edge. A single clock enable stalls all channels together, so alignment is never lost.

One quarter-wave table feeds all channels. The upper 12 accumulator bits form the phase. The two top bits pick the quadrant, which sets the mirroring and the sign. The cosine is read at the phase plus a quarter turn.

Top module: `mc_quad_nco`

## Requirements
- R1: While rst_ni is low, every I and Q output is 0. After release, all accumulators, active words and pending words are 0, so the first sample pair corresponds to phase 0.
- R2: On each clock with ce_i high and start_i low, each channel's accumulator grows by that channel's active tuning word.
- R3: With p equal to accumulator bits [31:20] in the cycle before an output edge, the channel's Q output equals round(32767·sin(2π(p+0.5)/4096)) and its I output equals round(32767·cos(2π(p+0.5)/4096)). The tolerance is ±1 LSB, and each output is a 16-bit two's complement field, with channel c at bits [16c+15:16c].
- R4: On a clock with start_i high, every accumulator becomes 0 on that edge, and every active word is loaded from its pending word.
- R5: A write (wr_en_i high, channel wr_ch_i, value wr_word_i) changes only that channel's pending word. Output frequencies do not change until the next start.
- R6: A write in the same cycle as start_i is not taken by that start. That start loads the earlier pending value, and the new word waits for the following start.
- R7: While ce_i is low, the accumulators hold. The outputs therefore repeat the last phase. A start with ce_i low still clears and loads.
- R8: The accumulator wraps modulo 2^32. A word of 0xFFFFFFFF steps the phase backwards through 4095.
- R9: Channels with equal active words give bit-identical outputs after a common start.
- R10: Q is non-negative for phases below 2048 and non-positive from 2048 up. For example, phase 2048 gives Q = -25 and I = -32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Common clock enable for all accumulators |
| start_i | input | 1 | Common start: clear accumulators, load pending words |
| wr_en_i | input | 1 | Pending tuning word write strobe |
| wr_ch_i | input | 3 | Channel index of the write |
| wr_word_i | input | 32 | Tuning word written |
| i_o | output | 128 | Cosine samples, 16 bits per channel |
| q_o | output | 128 | Sine samples, 16 bits per channel |

## Verification
Two functions can land in the same cycle: the common start and a tuning-word write. The bench provokes this by raising wr_en_i together with start_i for one clock. It then judges the result from the output progression after that start, which must follow the earlier pending word. The new word must appear only after a second start. A start together with a low clock enable is also provoked. It must still zero the phases while the stall holds them.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam real PI = 3.14159265358979323846;

  function automatic real taylor_sin(real x);
    real term = x;
    real sum = x;
    for (int n = 1; n < 10; n++) begin
      term = -term * x * x / real'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // entry k holds amp*sin at the midpoint of quarter-wave bin k
  function automatic int qsin_entry(int k, int aw, int amp);
    real x = PI / 2.0 * (real'(k) + 0.5) / real'(1 << aw);
    return int'(real'(amp) * taylor_sin(x));
  endfunction
endpackage

// File: rtl/nco_qlut.sv
module nco_qlut #(
  parameter int AW     = 10,
  parameter int OUT_W  = 16,
  parameter int N_PORT = 8,
  localparam int PH_W  = AW + 2
) (
  input  logic [PH_W-1:0]         phase_i [N_PORT],
  output logic signed [OUT_W-1:0] sin_o   [N_PORT],
  output logic signed [OUT_W-1:0] cos_o   [N_PORT]
);
  localparam int AMP  = (1 << (OUT_W - 1)) - 1;
  localparam int ROWS = 1 << AW;
  localparam logic [PH_W-1:0] QUARTER = PH_W'(ROWS);

  logic [OUT_W-2:0] rom [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_rom
    localparam int V = nco_pkg::qsin_entry(g, AW, AMP);
    assign rom[g] = (OUT_W-1)'(V);
  end

  function automatic logic signed [OUT_W-1:0] look(logic [PH_W-1:0] p);
    logic [AW-1:0] idx;
    logic signed [OUT_W-1:0] mag;
    idx = p[AW] ? ~p[AW-1:0] : p[AW-1:0];
    mag = signed'({1'b0, rom[idx]});
    return p[AW+1] ? -mag : mag;
  endfunction

  always_comb begin
    for (int p = 0; p < N_PORT; p++) begin
      sin_o[p] = look(phase_i[p]);
      cos_o[p] = look(phase_i[p] + QUARTER);
    end
  end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             start_i,
  input  logic             wr_en_i,
  input  logic [ACC_W-1:0] wr_word_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] pend_q, act_q, acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      acc_q  <= '0;
    end else begin
      if (wr_en_i) pend_q <= wr_word_i;
      if (start_i) begin
        act_q <= pend_q;
        acc_q <= '0;
      end else if (ce_i) begin
        acc_q <= acc_q + act_q;
      end
    end
  end

  assign phase_o = acc_q[ACC_W-1 -: PH_W];

  p_start_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> acc_q == '0 && act_q == $past(pend_q));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !start_i) |=> acc_q == $past(acc_q) + $past(act_q));
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !start_i) |=> $stable(acc_q));
  p_active_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(act_q));
endmodule

// File: rtl/mc_quad_nco.sv
module mc_quad_nco #(
  parameter int N_CH   = 8,
  parameter int ACC_W  = 32,
  parameter int LUT_AW = 10,
  parameter int OUT_W  = 16,
  localparam int PH_W  = LUT_AW + 2,
  localparam int CH_W  = $clog2(N_CH)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ce_i,
  input  logic                    start_i,
  input  logic                    wr_en_i,
  input  logic [CH_W-1:0]         wr_ch_i,
  input  logic [ACC_W-1:0]        wr_word_i,
  output logic [N_CH*OUT_W-1:0]   i_o,
  output logic [N_CH*OUT_W-1:0]   q_o
);
  logic [PH_W-1:0]         phase [N_CH];
  logic signed [OUT_W-1:0] s_lut [N_CH];
  logic signed [OUT_W-1:0] c_lut [N_CH];
  logic signed [OUT_W-1:0] i_q   [N_CH];
  logic signed [OUT_W-1:0] q_q   [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    nco_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ce_i     (ce_i),
      .start_i  (start_i),
      .wr_en_i  (wr_en_i && (wr_ch_i == CH_W'(c))),
      .wr_word_i(wr_word_i),
      .phase_o  (phase[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        i_q[c] <= '0;
        q_q[c] <= '0;
      end else begin
        i_q[c] <= c_lut[c];
        q_q[c] <= s_lut[c];
      end
    end

    assign i_o[c*OUT_W +: OUT_W] = i_q[c];
    assign q_o[c*OUT_W +: OUT_W] = q_q[c];

    p_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> phase[c] == phase[0]);
    p_q_sign_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ($past(phase[c][PH_W-1]) ? (q_q[c] <= 0) : (q_q[c] >= 0)));
  end

  nco_qlut #(.AW(LUT_AW), .OUT_W(OUT_W), .N_PORT(N_CH)) u_lut (
    .phase_i(phase),
    .sin_o  (s_lut),
    .cos_o  (c_lut)
  );
endmodule

// File: tb/tb_mc_quad_nco.sv
module tb_mc_quad_nco;
  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_i = 1'b0, start_i = 1'b0, wr_en_i = 1'b0;
  logic [2:0]  wr_ch_i = '0;
  logic [31:0] wr_word_i = '0;
  logic [127:0] i_o, q_o;

  int checks = 0, errors = 0;

  logic [31:0] m_acc [8];
  logic [31:0] m_act [8];
  logic [31:0] m_pend [8];
  int m_i [8];
  int m_q [8];

  // stimulus: pair words for 5/6/7/8 MHz plus 3749.941 Hz offset at 24 MHz
  localparam logic [31:0] WORDS [8] = '{
    32'd894784853,  32'd895455931,  32'd1073741824, 32'd1074412902,
    32'd1252698795, 32'd1253369873, 32'd1431655765, 32'd1432326843};

  mc_quad_nco dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i), .start_i(start_i),
    .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_word_i(wr_word_i),
    .i_o(i_o), .q_o(q_o));

  always #10 clk = ~clk;

  function automatic int exp_q(int p);
    return int'(32767.0 * $sin(2.0 * PI * (real'(p) + 0.5) / 4096.0));
  endfunction
  function automatic int exp_i(int p);
    return int'(32767.0 * $cos(2.0 * PI * (real'(p) + 0.5) / 4096.0));
  endfunction

  function automatic int get_i(int c);
    return int'($signed(i_o[c*16 +: 16]));
  endfunction
  function automatic int get_q(int c);
    return int'($signed(q_o[c*16 +: 16]));
  endfunction

  task automatic chk(string tag, int act, int expv, int tol);
    checks++;
    if (act > expv + tol || act < expv - tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic compare_all(string tag);
    for (int c = 0; c < 8; c++) begin
      chk(tag, get_i(c), m_i[c], 1);
      chk(tag, get_q(c), m_q[c], 1);
    end
  endtask

  task automatic step(string tag, bit ce, bit st, bit we, int ch, logic [31:0] w);
    ce_i = ce; start_i = st; wr_en_i = we; wr_ch_i = 3'(ch); wr_word_i = w;
    @(posedge clk);
    for (int c = 0; c < 8; c++) begin
      m_q[c] = exp_q(int'(m_acc[c][31:20]));
      m_i[c] = exp_i(int'(m_acc[c][31:20]));
      if (st) begin
        m_acc[c] = '0;
        m_act[c] = m_pend[c];
      end else if (ce) begin
        m_acc[c] = m_acc[c] + m_act[c];
      end
    end
    if (we) m_pend[ch] = w;
    @(negedge clk);
    ce_i = 1'b0; start_i = 1'b0; wr_en_i = 1'b0;
    compare_all(tag);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      m_acc[c] = '0; m_act[c] = '0; m_pend[c] = '0; m_i[c] = 0; m_q[c] = 0;
    end
    repeat (3) @(negedge clk);
    compare_all("R1 reset outputs");
    rst_ni = 1'b1;
    step("R1 first sample phase 0", 1, 0, 0, 0, 0);
    chk("R1 q at phase 0", get_q(0), 25, 1);
    chk("R1 i at phase 0", get_i(0), 32767, 1);

    // table walk: load pair words, common start, run
    for (int k = 0; k < 8; k++) step("R5 pending write no effect", 1, 0, 1, k, WORDS[k]);
    step("R4 common start", 1, 1, 0, 0, 0);
    for (int n = 0; n < 150; n++) step("R3 R2 running pairs", 1, 0, 0, 0, 0);

    // stall, start under stall
    for (int n = 0; n < 5; n++) step("R7 stall holds", 0, 0, 0, 0, 0);
    step("R7 start while stalled", 0, 1, 0, 0, 0);
    step("R7 stalled after start", 0, 0, 0, 0, 0);
    for (int n = 0; n < 4; n++) step("R2 resume", 1, 0, 0, 0, 0);

    // write mid-run: no effect until start
    step("R5 write ch2", 1, 0, 1, 2, 32'h1000_0000);
    for (int n = 0; n < 6; n++) step("R5 old word still active", 1, 0, 0, 0, 0);

    // write in same cycle as start
    step("R6 write with start", 1, 1, 1, 3, 32'h0800_0000);
    for (int n = 0; n < 6; n++) step("R6 start used old pending", 1, 0, 0, 0, 0);
    step("R6 second start", 1, 1, 0, 0, 0);
    for (int n = 0; n < 6; n++) step("R6 new word active", 1, 0, 0, 0, 0);

    // wrap and sign corners
    step("R8 write all-ones", 1, 0, 1, 4, 32'hFFFF_FFFF);
    step("R10 write half turn", 1, 0, 1, 5, 32'h8000_0000);
    step("R9 write ch0", 1, 0, 1, 0, 32'h0123_4567);
    step("R9 write ch1", 1, 0, 1, 1, 32'h0123_4567);
    step("R8 start", 1, 1, 0, 0, 0);
    for (int n = 0; n < 12; n++) begin
      step("R8 R10 corners", 1, 0, 0, 0, 0);
      chk("R9 equal words identical I", get_i(1), get_i(0), 0);
      chk("R9 equal words identical Q", get_q(1), get_q(0), 0);
    end
    // ch5 alternates phase 0 and 2048; ch4 walks 0,4095,...
    step("R10 half turn", 1, 0, 0, 0, 0);
    if (m_acc[5][31]) begin
      chk("R10 q at phase 0", get_q(5), 25, 1);
    end else begin
      chk("R10 q at phase 2048", get_q(5), -25, 1);
      chk("R10 i at phase 2048", get_i(5), -32767, 1);
    end
    chk("R8 wrapped phase q negative", (get_q(4) <= 0) ? 1 : 0, 1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule